// File: doc/BRIEF.md
# Dual-Rail Null-Convention Multiplexer Stage with Completion

This block is one stage of a delay-insensitive pipeline built on null-convention signalling and modelled at the clocked level. Every data bit travels on two rails. A stage alternates between two wavefronts: a DATA wavefront, where each bit has exactly one rail high, and a NULL wavefront, where every rail is low. The functional part is a bitwise dual-rail multiplexer: a shared dual-rail select steers word `a` or word `b` onto the output word `z`.

The rails of `z` are held by a register of hysteresis (C-element style) cells. A cell rises only when its rail input is high and the downstream stage asks for DATA. It falls only when its rail input is low and the downstream stage asks for NULL. In every other case it holds. A completion detector on each input word raises a per-input go signal once the whole word is DATA and lowers it once the whole word is NULL. A further C-element joins the three input go signals with the completion of the output word to form `z_go`. `z_go` therefore acknowledges every input, including the word that the select did not pick. `z_go` high tells the upstream stage that a DATA wavefront has been consumed. `z_go` low tells it that a NULL wavefront has been consumed.

Top module: `ncl_mux_stage`

## Requirements
- R1: Rail encoding per bit is {r1,r0}: 00 = NULL, 01 = DATA value 0, 10 = DATA value 1, and 11 is illegal. With legal inputs, no output bit ever has both rails high.
- R2: While `rst_n` is low, all output rails are low (NULL), and `go_a`, `go_b`, `go_s` and `z_go` are low.
- R3: When select is DATA1 (`s_r1`=1), output bit i takes the rails of `a` bit i. When select is DATA0 (`s_r0`=1), it takes the rails of `b` bit i. When select is NULL, both rails are low. The registered result appears one clock after the edge at which it was applied, provided the hysteresis rule allows it.
- R4: An output rail rises only at an edge where `ack_in` is high. While `ack_in` is low, a DATA wavefront arriving on a NULL output leaves the output NULL.
- R5: An output rail falls only at an edge where `ack_in` is low. While `ack_in` is high, a NULL wavefront arriving on a DATA output leaves the output unchanged.
- R6: `go_a` (also `go_b`, `go_s`) goes high one clock after every bit of its input is DATA. It goes low one clock after every bit is NULL. It holds its value while the input word is partly DATA and partly NULL.
- R7: `z_go` goes high one clock after `go_a`, `go_b` and `go_s` are all high and every output bit is DATA. It goes low one clock after all three are low and every output bit is NULL. In every other case it holds, so a NULL word on the unselected input keeps `z_go` low.
- R8: While the output word is partly DATA and partly NULL, `z_go` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the clocked model of the hysteresis cells |
| rst_n | input | 1 | Active-low synchronous reset |
| a_r0 | input | W | Rail 0 of input word a |
| a_r1 | input | W | Rail 1 of input word a |
| b_r0 | input | W | Rail 0 of input word b |
| b_r1 | input | W | Rail 1 of input word b |
| s_r0 | input | 1 | Select rail 0 (DATA0 picks b) |
| s_r1 | input | 1 | Select rail 1 (DATA1 picks a) |
| ack_in | input | 1 | Downstream request: high asks for DATA, low asks for NULL |
| z_r0 | output | W | Rail 0 of registered output word |
| z_r1 | output | W | Rail 1 of registered output word |
| go_a | output | 1 | Completion of input a |
| go_b | output | 1 | Completion of input b |
| go_s | output | 1 | Completion of the select |
| z_go | output | 1 | Stage acknowledge joining all input completions and the output completion |

## Verification
The bench builds the stage with a word width of 3. This is wide enough to drive a word that is partly DATA and partly NULL, and to reach the hold cases of every completion detector. It is also narrow enough that each wavefront is easy to follow. Partial words, an unselected input left NULL, and requests that arrive against `ack_in` are all applied in turn against a behavioural model of the handshake.

// File: rtl/ncl_pkg.sv
package ncl_pkg;

  // Hysteresis update: set when every input is high, clear when every input is low, else hold.
  function automatic logic c_next(input logic all_hi, input logic all_lo, input logic q);
    if (all_hi)      return 1'b1;
    else if (all_lo) return 1'b0;
    else             return q;
  endfunction

  // Dual-rail two-way select, result packed as {rail1, rail0}.
  function automatic logic [1:0] mux_rails(input logic a1, input logic a0,
                                           input logic b1, input logic b0,
                                           input logic s1, input logic s0);
    return {(a1 & s1) | (s0 & b1), (a0 & s1) | (s0 & b0)};
  endfunction

endpackage

// File: rtl/ncl_compl.sv
module ncl_compl #(
  parameter int W = 4
) (
  input  logic [W-1:0] r0,
  input  logic [W-1:0] r1,
  output logic         all_data,
  output logic         all_null
);
  logic [W-1:0] bit_done;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign bit_done[i] = r0[i] | r1[i];
  end

  assign all_data = &bit_done;
  assign all_null = ~|bit_done;
endmodule

// File: rtl/ncl_rail_reg.sv
module ncl_rail_reg #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d0,
  input  logic [W-1:0] d1,
  input  logic         ack,
  output logic [W-1:0] q0,
  output logic [W-1:0] q1
);
  import ncl_pkg::*;

  for (genvar i = 0; i < W; i++) begin : g_cell
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        q0[i] <= 1'b0;
        q1[i] <= 1'b0;
      end else begin
        q0[i] <= c_next(d0[i] & ack, ~d0[i] & ~ack, q0[i]);
        q1[i] <= c_next(d1[i] & ack, ~d1[i] & ~ack, q1[i]);
      end
    end
  end
endmodule

// File: rtl/ncl_mux_stage.sv
module ncl_mux_stage #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_r0,
  input  logic [W-1:0] a_r1,
  input  logic [W-1:0] b_r0,
  input  logic [W-1:0] b_r1,
  input  logic         s_r0,
  input  logic         s_r1,
  input  logic         ack_in,
  output logic [W-1:0] z_r0,
  output logic [W-1:0] z_r1,
  output logic         go_a,
  output logic         go_b,
  output logic         go_s,
  output logic         z_go
);
  import ncl_pkg::*;

  // Functional part: combinational dual-rail select
  logic [W-1:0] f_r0, f_r1;
  for (genvar i = 0; i < W; i++) begin : g_mux
    assign {f_r1[i], f_r0[i]} = mux_rails(a_r1[i], a_r0[i], b_r1[i], b_r0[i], s_r1, s_r0);
  end

  // Stage register of hysteresis cells, gated by downstream request
  ncl_rail_reg #(.W(W)) u_reg (
    .clk(clk), .rst_n(rst_n),
    .d0(f_r0), .d1(f_r1), .ack(ack_in),
    .q0(z_r0), .q1(z_r1)
  );

  // Completion detection on each input and on the output
  logic a_all_data, a_all_null, b_all_data, b_all_null;
  logic s_all_data, s_all_null, out_all_data, out_all_null;

  ncl_compl #(.W(W)) u_cd_a (.r0(a_r0), .r1(a_r1), .all_data(a_all_data), .all_null(a_all_null));
  ncl_compl #(.W(W)) u_cd_b (.r0(b_r0), .r1(b_r1), .all_data(b_all_data), .all_null(b_all_null));
  ncl_compl #(.W(1)) u_cd_s (.r0(s_r0), .r1(s_r1), .all_data(s_all_data), .all_null(s_all_null));
  ncl_compl #(.W(W)) u_cd_z (.r0(z_r0), .r1(z_r1), .all_data(out_all_data), .all_null(out_all_null));

  // Joining events brought out for the checker
  logic join_set, join_clr;
  assign join_set = go_a & go_b & go_s & out_all_data;
  assign join_clr = ~go_a & ~go_b & ~go_s & out_all_null;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      go_a <= 1'b0;
      go_b <= 1'b0;
      go_s <= 1'b0;
      z_go <= 1'b0;
    end else begin
      go_a <= c_next(a_all_data, a_all_null, go_a);
      go_b <= c_next(b_all_data, b_all_null, go_b);
      go_s <= c_next(s_all_data, s_all_null, go_s);
      z_go <= c_next(join_set, join_clr, z_go);
    end
  end
endmodule

// File: rtl/ncl_mux_stage_chk.sv
module ncl_mux_stage_chk #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] a_r0,
  input logic [W-1:0] a_r1,
  input logic         ack_in,
  input logic [W-1:0] z_r0,
  input logic [W-1:0] z_r1,
  input logic         go_a,
  input logic         go_b,
  input logic         go_s,
  input logic         z_go,
  input logic         out_all_data,
  input logic         out_all_null
);
  logic [W-1:0] z_any;
  assign z_any = z_r0 | z_r1;

  p_legal_rails_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (z_r0 & z_r1) == '0);

  p_rise_needs_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|(z_any & ~$past(z_any))) |-> $past(ack_in));

  p_fall_needs_noack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|(~z_any & $past(z_any))) |-> !$past(ack_in));

  p_goa_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(go_a) |-> $past((a_r0 | a_r1) == '1));

  p_goa_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(go_a) |-> $past((a_r0 | a_r1) == '0));

  p_zgo_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(z_go) |-> $past(go_a && go_b && go_s && out_all_data));

  p_zgo_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(z_go) |-> $past(!go_a && !go_b && !go_s && out_all_null));

  p_zgo_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!out_all_data && !out_all_null) |-> $stable(z_go));
endmodule

bind ncl_mux_stage ncl_mux_stage_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .a_r0(a_r0), .a_r1(a_r1), .ack_in(ack_in),
  .z_r0(z_r0), .z_r1(z_r1), .go_a(go_a), .go_b(go_b), .go_s(go_s), .z_go(z_go),
  .out_all_data(out_all_data), .out_all_null(out_all_null)
);

// File: tb/ncl_mux_stage_bench.sv
module ncl_mux_stage_bench;
  localparam int BW = 3;
  localparam time CLK_PERIOD = 10ns;
  localparam int WATCHDOG = 5000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Stimulus as (valid mask, value) pairs
  logic [BW-1:0] av = '0, ad = '0, bv = '0, bd = '0;
  logic sv = 1'b0, sd = 1'b0, ack = 1'b0;

  logic [BW-1:0] z_r0, z_r1;
  logic go_a, go_b, go_s, z_go;

  ncl_mux_stage #(.W(BW)) u_ncl_mux_stage (
    .clk(clk), .rst_n(rst_n),
    .a_r0(av & ~ad), .a_r1(av & ad),
    .b_r0(bv & ~bd), .b_r1(bv & bd),
    .s_r0(sv & ~sd), .s_r1(sv & sd),
    .ack_in(ack),
    .z_r0(z_r0), .z_r1(z_r1),
    .go_a(go_a), .go_b(go_b), .go_s(go_s), .z_go(z_go)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // Reference model state
  int mz[BW];            // 0 = NULL, 1 = DATA0, 2 = DATA1
  int mga, mgb, mgs, mzg;

  task automatic check(string req, string what, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int word_go(logic [BW-1:0] v, int prev);
    if (v == '1) return 1;
    if (v == '0) return 0;
    return prev;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < BW; i++) mz[i] = 0;
    mga = 0; mgb = 0; mgs = 0; mzg = 0;
  endtask

  task automatic model_clock();
    int nz[BW];
    int want, full, empty;
    full = 1; empty = 1;
    for (int i = 0; i < BW; i++) begin
      if (mz[i] == 0) full = 0; else empty = 0;
    end
    for (int i = 0; i < BW; i++) begin
      want = 0;
      if (sv && sd && av[i])       want = ad[i] ? 2 : 1;
      else if (sv && !sd && bv[i]) want = bd[i] ? 2 : 1;
      nz[i] = mz[i];
      if (ack && mz[i] == 0 && want != 0) nz[i] = want;
      else if (!ack && mz[i] != 0 && want != mz[i]) nz[i] = 0;
    end
    if (mga && mgb && mgs && full)          mzg = 1;
    else if (!mga && !mgb && !mgs && empty) mzg = 0;
    mga = word_go(av, mga);
    mgb = word_go(bv, mgb);
    mgs = word_go({BW{sv}}, mgs);
    for (int i = 0; i < BW; i++) mz[i] = nz[i];
  endtask

  task automatic compare(string req);
    for (int i = 0; i < BW; i++) begin
      check("R1", "rail pair", int'(z_r0[i] & z_r1[i]), 0);
      check(req, $sformatf("z bit %0d", i), int'({z_r1[i], z_r0[i]}), mz[i]);
    end
    check("R6", "go_a", int'(go_a), mga);
    check("R6", "go_b", int'(go_b), mgb);
    check("R6", "go_s", int'(go_s), mgs);
    check("R7", "z_go", int'(z_go), mzg);
  endtask

  task automatic step(string req, int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      model_clock();
      @(negedge clk);
      compare(req);
    end
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    // R2: reset state
    check("R2", "z_r0", int'(z_r0), 0);
    check("R2", "z_r1", int'(z_r1), 0);
    check("R2", "go flags", int'({go_a, go_b, go_s, z_go}), 0);
    rst_n = 1'b1;

    // R3: select a (DATA1), full handshake
    ack = 1; av = '1; ad = 3'b101; bv = '1; bd = 3'b010; sv = 1; sd = 1;
    step("R3", 3);
    check("R7", "z_go after full DATA", int'(z_go), 1);
    ack = 0; av = '0; bv = '0; sv = 0;
    step("R3", 3);
    check("R7", "z_go after full NULL", int'(z_go), 0);

    // R3: select b (DATA0)
    ack = 1; av = '1; ad = 3'b000; bv = '1; bd = 3'b110; sv = 1; sd = 0;
    step("R3", 3);
    check("R3", "z_r1 selects b", int'(z_r1), 6);
    ack = 0; av = '0; bv = '0; sv = 0;
    step("R3", 3);

    // R7: unselected input left NULL keeps z_go low
    ack = 1; av = '1; ad = 3'b011; bv = '0; sv = 1; sd = 1;
    step("R7", 3);
    check("R7", "z_go waits for b", int'(z_go), 0);
    bv = '1; bd = 3'b111;
    step("R7", 3);
    check("R7", "z_go once b arrives", int'(z_go), 1);

    // R5: NULL while ack high leaves DATA on output
    av = '0; bv = '0; sv = 0;
    step("R5", 2);
    check("R5", "z_r1 held", int'(z_r1), 3);
    ack = 0;
    step("R5", 3);
    check("R5", "z cleared after ack low", int'(z_r0 | z_r1), 0);

    // R4: DATA while ack low leaves output NULL
    av = '1; ad = 3'b100; bv = '1; bd = 3'b001; sv = 1; sd = 1;
    step("R4", 2);
    check("R4", "z held NULL", int'(z_r0 | z_r1), 0);
    ack = 1;
    step("R4", 3);

    // R6, R8: partly valid words
    ack = 0; av = 3'b011; bv = '0; sv = 0;
    step("R6", 3);
    check("R6", "go_a holds high on mixed word", int'(go_a), 1);
    av = '0;
    step("R6", 3);
    ack = 1; av = 3'b010; ad = 3'b111; bv = '1; bd = 3'b000; sv = 1; sd = 1;
    step("R8", 3);
    check("R8", "z_go holds on partial output", int'(z_go), 0);
    av = '1;
    step("R8", 3);
    check("R8", "z_go after completion", int'(z_go), 1);
    ack = 0; av = 3'b100;
    bv = '0; sv = 0;
    step("R8", 3);
    check("R8", "z_go holds on partial NULL", int'(z_go), 1);
    av = '0;
    step("R8", 3);

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule